// File: doc/BRIEF.md
# Integrating Converter Sequencer

This block controls an external dual-slope style integrating converter. The converter has a 3-bit analog switch select, an integrating capacitor and a comparator flag that stays high while the capacitor is ramping. The sequencer drives the select lines through its phases. It measures each integration pulse by counting clock cycles while the comparator flag is high. It then hands the raw counts to a consumer, which forms the ratio (input − zero) / (reference − zero).

A conversion is requested with a channel number and a calibrate bit. With the calibrate bit set, the block discharges the capacitor and integrates ground. It discharges again and integrates the reference, then discharges once more and integrates the chosen channel. With the bit clear, it skips the two calibration phases and reports the zero and reference counts stored by the last calibrated run.

Each discharge is held for a programmed number of cycles. Each integration phase is bounded by a programmed limit, so a stuck comparator ends the run with an error flag.

Top module: `iadc_seq`

## Requirements
- R1: After reset and whenever no conversion is in progress, `sel_o` is 3'b111 and `busy_o` and `res_valid_o` are low.
- R2: The select codes are 000 for discharge, 001 for ground, 010 for reference, and 011+ch for channel ch (ch = 0..3). A calibrated conversion shows 000, 001, 000, 010, 000, 011+ch in that order, and then returns to 111.
- R3: Every discharge phase holds `sel_o` at 000 for exactly `hold_i`+1 clock cycles.
- R4: The count of an integration phase is the number of cycles during which the synchronized comparator flag is high in its first high pulse. The pulse counts only once the flag has been seen low inside the phase, so a flag that is already high on entry is not counted until it falls and rises again.
- R5: With the calibrate bit clear, the sequence is 000 followed by the channel code. The reported ground and reference counts are the last stored ones, which are 0 after reset.
- R6: If an integration phase has not ended after `limit_i` cycles, it lasts exactly `limit_i`+1 cycles. The block then discharges for `hold_i`+1 cycles and presents a result with `res_ovf_o`=1 and an input count of 0. A stored count is replaced only by a phase that ends normally.
- R7: `busy_o` rises in the cycle after an accepted start and falls after the result handshake. `res_valid_o` and the result fields stay stable until `res_ready_i`, and a start while busy is ignored.
- R8: `res_ch_o` reports the channel of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the block and pulse counting |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, taken only when idle |
| start_ch_i | input | 2 | Channel to convert |
| start_cal_i | input | 1 | 1 = measure ground and reference first |
| busy_o | output | 1 | Conversion or result pending |
| hold_i | input | DW | Discharge length minus one, in cycles |
| limit_i | input | CW | Cycle limit of an integration phase |
| sel_o | output | 3 | Analog switch select code |
| cmp_i | input | 1 | Asynchronous comparator flag |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer takes the result |
| res_gnd_o | output | CW | Zero-scale count |
| res_ref_o | output | CW | Reference-scale count |
| res_in_o | output | CW | Channel count |
| res_ch_o | output | 2 | Channel of this result |
| res_ovf_o | output | 1 | Run ended by phase timeout |

## Verification
Conversions are run with random pulse widths from 1 to 200 cycles, random discharge holds, random channels and a random choice between calibrated and reusing runs. Comparing the reported counts with the driven widths distinguishes correct counting from off-by-one sync latency, and the reusing runs show whether stored counts survive. A flag held high on phase entry separates edge-qualified counting from level counting. A flag that never falls, once in a channel phase and once in the ground phase, exercises the timeout length, the trailing discharge and the rule that stored counts stay untouched. Start requests raised during a pending result show whether the request is correctly ignored while busy.

// File: rtl/iadc_pkg.sv
package iadc_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_DIS, ST_INT, ST_RES} seq_st_t;
   typedef enum logic [1:0] {PH_GND, PH_REF, PH_CH} phase_t;

   localparam logic [2:0] SEL_DIS  = 3'b000;
   localparam logic [2:0] SEL_GND  = 3'b001;
   localparam logic [2:0] SEL_REF  = 3'b010;
   localparam logic [2:0] SEL_CH0  = 3'b011;
   localparam logic [2:0] SEL_IDLE = 3'b111;

   function automatic logic [2:0] phase_code(phase_t ph, logic [1:0] ch);
      case (ph)
         PH_GND:  return SEL_GND;
         PH_REF:  return SEL_REF;
         default: return 3'(SEL_CH0 + {1'b0, ch});
      endcase
   endfunction
endpackage

// File: rtl/iadc_sync.sv
module iadc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("iadc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d_i};
   end

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/iadc_pulse.sv
module iadc_pulse #(
   parameter int CW = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          en_i,
   input  logic          lvl_i,
   input  logic [CW-1:0] max_i,
   output logic          done_o,
   output logic          ovf_o,
   output logic [CW-1:0] cnt_o
);
   logic          armed_q, run_q;
   logic [CW-1:0] cnt_q, tmo_q;

   assign done_o = en_i & run_q & ~lvl_i;
   assign ovf_o  = en_i & ~done_o & (tmo_q >= max_i);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         armed_q <= 1'b0;
         run_q   <= 1'b0;
         cnt_q   <= '0;
         tmo_q   <= '0;
      end else if (en_i) begin
         if (tmo_q != '1) tmo_q <= tmo_q + 1'b1;
         if (!lvl_i) armed_q <= 1'b1;
         if (lvl_i && (armed_q || run_q)) begin
            run_q <= 1'b1;
            if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R4: the pulse count never exceeds the cycles spent in the phase
   a_r4_cnt_within_window: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= tmo_q);
   // R4: counting cannot begin before the flag has been seen low
   a_r4_no_count_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !clr_i && !armed_q && !run_q) |=> !run_q);
endmodule

// File: rtl/iadc_seq.sv
module iadc_seq
   import iadc_pkg::*;
#(
   parameter int CW          = 14,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [1:0]    start_ch_i,
   input  logic          start_cal_i,
   output logic          busy_o,
   input  logic [DW-1:0] hold_i,
   input  logic [CW-1:0] limit_i,
   output logic [2:0]    sel_o,
   input  logic          cmp_i,
   output logic          res_valid_o,
   input  logic          res_ready_i,
   output logic [CW-1:0] res_gnd_o,
   output logic [CW-1:0] res_ref_o,
   output logic [CW-1:0] res_in_o,
   output logic [1:0]    res_ch_o,
   output logic          res_ovf_o
);
   localparam int MIN_CW = 13;

   generate
      if (CW < MIN_CW) begin : g_bad_cw
         $error("iadc_seq: CW must hold a 12-bit full-scale pulse plus headroom");
      end
      if (DW < 1) begin : g_bad_dw
         $error("iadc_seq: DW must be positive");
      end
   endgenerate

   seq_st_t       st_q;
   phase_t        ph_q;
   logic          fin_q, ovf_q;
   logic [DW-1:0] dcnt_q;
   logic [1:0]    ch_q;
   logic [CW-1:0] gnd_q, ref_q, in_q;
   logic          lvl_s, p_done, p_ovf;
   logic [CW-1:0] p_cnt;
   logic          in_int;

   iadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(cmp_i), .q_o(lvl_s)
   );

   assign in_int = (st_q == ST_INT);

   iadc_pulse #(.CW(CW)) u_pulse (
      .clk(clk), .rst_n(rst_n), .clr_i(!in_int), .en_i(in_int),
      .lvl_i(lvl_s), .max_i(limit_i),
      .done_o(p_done), .ovf_o(p_ovf), .cnt_o(p_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ph_q   <= PH_GND;
         fin_q  <= 1'b0;
         ovf_q  <= 1'b0;
         dcnt_q <= '0;
         ch_q   <= '0;
         gnd_q  <= '0;
         ref_q  <= '0;
         in_q   <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start_i) begin
               ch_q   <= start_ch_i;
               ph_q   <= start_cal_i ? PH_GND : PH_CH;
               fin_q  <= 1'b0;
               ovf_q  <= 1'b0;
               in_q   <= '0;
               dcnt_q <= '0;
               st_q   <= ST_DIS;
            end
            ST_DIS: if (dcnt_q == hold_i) begin
               dcnt_q <= '0;
               st_q   <= fin_q ? ST_RES : ST_INT;
            end else begin
               dcnt_q <= dcnt_q + 1'b1;
            end
            ST_INT: if (p_done) begin
               case (ph_q)
                  PH_GND: begin gnd_q <= p_cnt; ph_q <= PH_REF; st_q <= ST_DIS; end
                  PH_REF: begin ref_q <= p_cnt; ph_q <= PH_CH;  st_q <= ST_DIS; end
                  default: begin in_q <= p_cnt; st_q <= ST_RES; end
               endcase
            end else if (p_ovf) begin
               ovf_q <= 1'b1;
               fin_q <= 1'b1;
               st_q  <= ST_DIS;
            end
            default: if (res_ready_i) st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st_q)
         ST_DIS:  sel_o = SEL_DIS;
         ST_INT:  sel_o = phase_code(ph_q, ch_q);
         default: sel_o = SEL_IDLE;
      endcase
   end

   assign busy_o      = (st_q != ST_IDLE);
   assign res_valid_o = (st_q == ST_RES);
   assign res_gnd_o   = gnd_q;
   assign res_ref_o   = ref_q;
   assign res_in_o    = in_q;
   assign res_ch_o    = ch_q;
   assign res_ovf_o   = ovf_q;

   // checker helper: length of the current run of discharge code
   logic [DW:0] dis_len_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                dis_len_q <= '0;
      else if (sel_o == SEL_DIS) dis_len_q <= dis_len_q + 1'b1;
      else                       dis_len_q <= '0;
   end

   // R3: a finished discharge run lasted exactly hold+1 cycles
   a_r3_dis_length: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o != SEL_DIS && dis_len_q != '0) |-> dis_len_q == ({1'b0, hold_i} + 1'b1));
   // R2: leaving the idle code always enters discharge
   a_r2_idle_to_dis: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel_o) == SEL_IDLE && sel_o != SEL_IDLE) |-> sel_o == SEL_DIS);
   // R2: an integration code is only followed by discharge or idle
   a_r2_int_exit: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel_o) != SEL_DIS && $past(sel_o) != SEL_IDLE && sel_o != $past(sel_o))
      |-> (sel_o == SEL_DIS || sel_o == SEL_IDLE));
   // R7: a pending result stays put until taken
   a_r7_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_in_o)
         && $stable(res_ch_o) && $stable(res_gnd_o) && $stable(res_ovf_o)));
   // R1: a result is only presented while busy and at the idle code
   a_r1_result_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> (busy_o && sel_o == SEL_IDLE));
endmodule

// File: tb/iadc_seq_bench.sv
module iadc_seq_bench;
   localparam int CW = 14;
   localparam int DW = 8;
   localparam int LIMIT = 600;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [1:0]    start_ch_i = '0;
   logic          start_cal_i = 1'b0;
   logic          busy_o;
   logic [DW-1:0] hold_i = '0;
   logic [CW-1:0] limit_i = CW'(LIMIT);
   logic [2:0]    sel_o;
   logic          cmp_i = 1'b0;
   logic          res_valid_o;
   logic          res_ready_i = 1'b0;
   logic [CW-1:0] res_gnd_o, res_ref_o, res_in_o;
   logic [1:0]    res_ch_o;
   logic          res_ovf_o;

   iadc_seq #(.CW(CW), .DW(DW)) u_iadc_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_ch_i(start_ch_i),
      .start_cal_i(start_cal_i), .busy_o(busy_o), .hold_i(hold_i), .limit_i(limit_i),
      .sel_o(sel_o), .cmp_i(cmp_i), .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
      .res_gnd_o(res_gnd_o), .res_ref_o(res_ref_o), .res_in_o(res_in_o),
      .res_ch_o(res_ch_o), .res_ovf_o(res_ovf_o)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   int exp_gnd = 0;
   int exp_ref = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_err = n_err + 1;
         $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk = n_chk + 1;
      if (act != exp) begin
         n_err = n_err + 1;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic int ch_code(input int ch);
      return 3 + ch;
   endfunction

   task automatic do_dis(input int hold);
      int n = 0;
      while (sel_o == 3'b000 && n < 1000) begin
         n++;
         tick();
      end
      chk("R3 discharge length", n, hold + 1);
   endtask

   // at a negedge inside the phase's first cycle
   task automatic do_phase(input int code, input int width, input bit hi_entry, input bit stuck);
      int n = 0;
      chk("R2 phase select code", int'(sel_o), code);
      if (stuck) begin
         cmp_i = 1'b1;
         while (int'(sel_o) == code && n < 5000) begin n++; tick(); end
         cmp_i = 1'b0;
         chk("R6 timed-out phase length", n, LIMIT + 1);
      end else begin
         if (hi_entry) begin
            repeat (3) tick();
            cmp_i = 1'b0;
         end
         repeat (2) tick();
         cmp_i = 1'b1;
         repeat (width) tick();
         cmp_i = 1'b0;
         while (int'(sel_o) == code && n < 5000) begin n++; tick(); end
      end
   endtask

   task automatic convert(input int ch, input bit cal, input int hold, input int g,
                          input int r, input int w, input bit hi_entry, input bit stuck);
      int e_in;
      bit ovf_done = 1'b0;
      hold_i = DW'(hold);
      tick();
      chk("R1 idle select before start", int'(sel_o), 7);
      chk("R1 not busy before start", int'(busy_o), 0);
      start_i = 1'b1; start_ch_i = 2'(ch); start_cal_i = cal;
      if (hi_entry) cmp_i = 1'b1;
      tick();
      start_i = 1'b0;
      chk("R7 busy after accepted start", int'(busy_o), 1);
      do_dis(hold);
      if (cal) begin
         do_phase(1, g, hi_entry, stuck);
         if (stuck) begin
            ovf_done = 1'b1;
            do_dis(hold);
         end else begin
            do_dis(hold);
            do_phase(2, r, 1'b0, 1'b0);
            do_dis(hold);
         end
      end
      if (!ovf_done) begin
         do_phase(ch_code(ch), w, 1'b0, stuck);
         if (stuck) do_dis(hold);
      end
      if (cal && !stuck) begin exp_gnd = g; exp_ref = r; end
      e_in = stuck ? 0 : w;
      chk("R2 idle code after run", int'(sel_o), 7);
      chk("R7 result valid", int'(res_valid_o), 1);
      chk("R4 channel count", int'(res_in_o), e_in);
      chk("R5 ground count", int'(res_gnd_o), exp_gnd);
      chk("R5 reference count", int'(res_ref_o), exp_ref);
      chk("R8 result channel", int'(res_ch_o), ch);
      chk("R6 overflow flag", int'(res_ovf_o), int'(stuck));
      start_i = 1'b1; start_ch_i = 2'(ch ^ 1); start_cal_i = 1'b1;
      repeat (2) tick();
      start_i = 1'b0;
      chk("R7 valid held without ready", int'(res_valid_o), 1);
      chk("R7 start ignored while busy", int'(res_ch_o), ch);
      chk("R7 select unchanged while pending", int'(sel_o), 7);
      res_ready_i = 1'b1;
      tick();
      res_ready_i = 1'b0;
      chk("R7 valid drops after handshake", int'(res_valid_o), 0);
      chk("R1 busy low after handshake", int'(busy_o), 0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) tick();
      chk("R1 reset select code", int'(sel_o), 7);
      chk("R1 reset busy", int'(busy_o), 0);
      chk("R1 reset valid", int'(res_valid_o), 0);
      rst_n = 1'b1;
      tick();
      // R5: reuse before any calibration reports zeros
      convert(2, 1'b0, 3, 0, 0, 77, 1'b0, 1'b0);
      // directed: minimum pulse, zero hold
      convert(0, 1'b1, 0, 1, 2, 1, 1'b0, 1'b0);
      // R4: flag high at entry must not be counted until it falls and rises
      convert(3, 1'b1, 5, 40, 150, 90, 1'b1, 1'b0);
      // R6: timeout in the channel phase, stored counts kept
      convert(1, 1'b0, 4, 0, 0, 0, 1'b0, 1'b1);
      // R6: timeout in the ground phase, stored counts kept
      convert(0, 1'b1, 2, 0, 0, 0, 1'b0, 1'b1);
      convert(1, 1'b0, 1, 0, 0, 33, 1'b0, 1'b0);
      for (int k = 0; k < 40; k++) begin
         int ch = int'($urandom % 4);
         bit cal = 1'($urandom % 2);
         int hold = int'($urandom % 13);
         int g = 1 + int'($urandom % 200);
         int r = 1 + int'($urandom % 200);
         int w = 1 + int'($urandom % 200);
         bit hi = cal & 1'($urandom % 2);
         convert(ch, cal, hold, g, r, w, hi, 1'b0);
      end
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule